// File: doc/BRIEF.md
# Cascadable BCD Counter Digit

This block is one decimal digit of a synchronous counter. It holds a 4-bit BCD value that can step through 0 to 9, be zeroed, be preset from a 4-bit data word, or hold. Every state bit updates on the same rising clock edge. The operating mode is decided only by the control levels present at that edge.

There are two count enables. The local enable only gates stepping. The chain enable also gates the carry output, which is high while the digit sits at nine. To build a multi-digit counter, connect each digit's carry output to the chain enable of the next digit and share the local enable and clock. All digits then roll over on the same edge with no extra gating.

There is no reset input. A value of ten to fifteen, left by start-up or by a preset, returns to the decimal range within two counting edges along a fixed path.

Top module: `bcd_chain_digit`

## Requirements
- R1: With clear_n low at a rising edge, count becomes 0 on that edge, whatever preset_n, cnt_en and chain_en are.
- R2: With clear_n high and preset_n low at a rising edge, count takes preset_val on that edge, whatever the enables are. Codes 10 to 15 are accepted as they are.
- R3: With clear_n and preset_n high and both cnt_en and chain_en high, count advances 0→1→…→9→0 by one per rising edge.
- R4: With clear_n and preset_n high and either enable low, count keeps its value across the edge.
- R5: carry_out is high exactly when chain_en is high and count equals 9 (4'b1001). It follows chain_en with no clock edge in between.
- R6: While counting, the codes 10 to 15 move along 10→11→6, 12→13→4 and 14→15→2, so the digit reaches 0 to 9 within two counting edges.
- R7: When the carry output of one digit drives the chain enable of a second digit, the pair counts 00 to 99 and wraps to 00. The high digit's carry is high only at 99.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low synchronous zeroing, highest priority |
| preset_n | input | 1 | Active-low synchronous parallel preset |
| preset_val | input | 4 | Value taken on a preset |
| cnt_en | input | 1 | Local count enable |
| chain_en | input | 1 | Chained count enable, also gates carry_out |
| count | output | 4 | Registered digit value |
| carry_out | output | 1 | Digit-at-nine carry for the next stage |

## Verification
Two digits are chained and counted through all hundred combined values and past the wrap. This shows whether the carry handoff and the rollover of both digits happen on the correct edge. All sixteen preset codes are loaded and then stepped twice, which separates correct preset capture from the fixed recovery path of codes ten to fifteen. Each enable is lowered alone, and the preset and zeroing inputs are combined with conflicting enables, to check hold and priority. chain_en is toggled at nine between clock edges to show that the carry is combinational.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned LAST_DIGIT = 9;
  localparam int unsigned FOLD_BASE  = 17;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_STEP = 2'd1,
    MODE_LOAD = 2'd2,
    MODE_ZERO = 2'd3
  } mode_e;
endpackage

// File: rtl/bcd_mode_sel.sv
module bcd_mode_sel
  import bcd_pkg::*;
(
  input  logic  clear_n,
  input  logic  preset_n,
  input  logic  cnt_en,
  input  logic  chain_en,
  output mode_e mode
);
  always_comb begin
    if (!clear_n)                mode = MODE_ZERO;
    else if (!preset_n)          mode = MODE_LOAD;
    else if (cnt_en && chain_en) mode = MODE_STEP;
    else                         mode = MODE_HOLD;
  end
endmodule

// File: rtl/bcd_successor.sv
module bcd_successor
  import bcd_pkg::*;
(
  input  digit_t cur,
  output digit_t nxt
);
  localparam digit_t LAST = digit_t'(LAST_DIGIT);

  // Decimal range wraps at LAST. Above it, even codes step up by one
  // and odd codes fold back into the decimal range.
  always_comb begin
    if (cur < LAST)
      nxt = cur + digit_t'(1);
    else if (cur == LAST)
      nxt = '0;
    else if (cur[0])
      nxt = digit_t'(FOLD_BASE[DIGIT_W:0] - {1'b0, cur});
    else
      nxt = cur + digit_t'(1);
  end
endmodule

// File: rtl/bcd_chain_digit.sv
module bcd_chain_digit
  import bcd_pkg::*;
(
  input  logic               clk,
  input  logic               clear_n,
  input  logic               preset_n,
  input  logic [DIGIT_W-1:0] preset_val,
  input  logic               cnt_en,
  input  logic               chain_en,
  output logic [DIGIT_W-1:0] count,
  output logic               carry_out
);
  localparam digit_t LAST = digit_t'(LAST_DIGIT);

  mode_e  mode;
  digit_t count_q;
  digit_t step_val;

  bcd_mode_sel u_mode (
    .clear_n  (clear_n),
    .preset_n (preset_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .mode     (mode)
  );

  bcd_successor u_succ (
    .cur (count_q),
    .nxt (step_val)
  );

  always_ff @(posedge clk) begin
    case (mode)
      MODE_ZERO: count_q <= '0;
      MODE_LOAD: count_q <= preset_val;
      MODE_STEP: count_q <= step_val;
      default:   count_q <= count_q;
    endcase
  end

  assign count     = count_q;
  assign carry_out = chain_en && (count_q == LAST);
endmodule

// File: rtl/bcd_chain_digit_chk.sv
module bcd_chain_digit_chk
  import bcd_pkg::*;
(
  input logic               clk,
  input logic               clear_n,
  input logic               preset_n,
  input logic [DIGIT_W-1:0] preset_val,
  input logic               cnt_en,
  input logic               chain_en,
  input logic [DIGIT_W-1:0] count,
  input logic               carry_out
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  logic stepping;
  assign stepping = clear_n && preset_n && cnt_en && chain_en;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!seen)
    !clear_n |=> (count == '0)); // R1
  AST_PRESET_TAKEN: assert property (@(posedge clk) disable iff (!seen)
    (clear_n && !preset_n) |=> (count == $past(preset_val))); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!seen)
    (stepping && count < 4'd9) |=> (count == $past(count) + 4'd1)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!seen)
    (stepping && count == 4'd9) |=> (count == '0)); // R3
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!seen)
    (clear_n && preset_n && !(cnt_en && chain_en)) |=> $stable(count)); // R4
  AST_CARRY_AT_NINE: assert property (@(posedge clk) disable iff (!seen)
    carry_out |-> (count == 4'd9 && chain_en)); // R5
  AST_FOLD_BACK: assert property (@(posedge clk) disable iff (!seen)
    (stepping && count > 4'd9 && count[0]) |=> (count < 4'd9)); // R6
endmodule

bind bcd_chain_digit bcd_chain_digit_chk u_chk (
  .clk        (clk),
  .clear_n    (clear_n),
  .preset_n   (preset_n),
  .preset_val (preset_val),
  .cnt_en     (cnt_en),
  .chain_en   (chain_en),
  .count      (count),
  .carry_out  (carry_out)
);

// File: tb/bcd_chain_digit_bench.sv
module bcd_chain_digit_bench;
  logic       clk = 1'b0;
  logic       clear_n = 1'b0;
  logic       preset_n = 1'b1;
  logic [3:0] val_lo = 4'd0;
  logic [3:0] val_hi = 4'd0;
  logic       cnt_en = 1'b0;
  logic       chain_lo = 1'b0;
  logic [3:0] cnt_lo, cnt_hi;
  logic       carry_lo, carry_hi;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_chain_digit u_bcd_chain_digit (
    .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .preset_val(val_lo),
    .cnt_en(cnt_en), .chain_en(chain_lo), .count(cnt_lo), .carry_out(carry_lo)
  );

  bcd_chain_digit u_bcd_chain_digit_hi (
    .clk(clk), .clear_n(clear_n), .preset_n(preset_n), .preset_val(val_hi),
    .cnt_en(cnt_en), .chain_en(carry_lo), .count(cnt_hi), .carry_out(carry_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int next_code(input int v);
    case (v)
      9:  return 0;
      11: return 6;   // R6
      13: return 4;   // R6
      15: return 2;   // R6
      default: return v + 1;
    endcase
  endfunction

  initial begin
    // R1: zeroing with preset and enables active
    clear_n = 0; preset_n = 0; val_lo = 4'd7; val_hi = 4'd3;
    cnt_en = 1; chain_lo = 1;
    tick();
    chk("R1 lo", cnt_lo, 0);
    chk("R1 hi", cnt_hi, 0);

    // R7 and R3: cascade over the full range and past the wrap
    preset_n = 1; clear_n = 1;
    #1;
    chk("R7 carry at 00", carry_hi, 0);
    for (int i = 1; i <= 105; i++) begin
      tick();
      chk("R3 lo digit", cnt_lo, (i % 100) % 10);
      chk("R7 hi digit", cnt_hi, (i % 100) / 10);
      chk("R7 hi carry", carry_hi, ((i % 100) == 99) ? 1 : 0);
    end

    // R2: preset with both enables low
    cnt_en = 0; chain_lo = 0; preset_n = 0; val_lo = 4'd9; val_hi = 4'd0;
    tick();
    chk("R2 preset ignores enables", cnt_lo, 9);

    // R4: hold with one enable low at a time
    preset_n = 1; cnt_en = 0; chain_lo = 1;
    tick();
    chk("R4 hold cnt_en low", cnt_lo, 9);
    cnt_en = 1; chain_lo = 0;
    tick();
    chk("R4 hold chain_en low", cnt_lo, 9);

    // R5: carry follows chain_en between edges
    cnt_en = 0;
    @(negedge clk);
    chain_lo = 1; #1;
    chk("R5 carry with chain_en high", carry_lo, 1);
    chain_lo = 0; #1;
    chk("R5 carry with chain_en low", carry_lo, 0);
    chain_lo = 1; val_lo = 4'd8; preset_n = 0;
    tick();
    chk("R5 carry away from nine", carry_lo, 0);

    // R1: zeroing overrides a preset and both enables
    clear_n = 0; preset_n = 0; val_lo = 4'd5; cnt_en = 1; chain_lo = 1;
    tick();
    chk("R1 overrides preset", cnt_lo, 0);
    clear_n = 1;

    // R2 and R6: every code preset and stepped twice
    for (int v = 0; v < 16; v++) begin
      preset_n = 0; val_lo = 4'(v); cnt_en = 0; chain_lo = 0;
      tick();
      chk("R2 preset code", cnt_lo, v);
      preset_n = 1; cnt_en = 1; chain_lo = 1;
      tick();
      chk("R6 first step", cnt_lo, next_code(v));
      tick();
      chk("R6 second step", cnt_lo, next_code(next_code(v)));
      chk("R6 back in range", (cnt_lo < 10) ? 1 : 0, 1);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule